// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a pipelined synchronous burst SRAM. It has a 32-bit word split into four byte lanes. Every synchronous input is captured on the rising clock edge. An access starts when one of two active-low address strobes is asserted. The *processor* strobe (`strb_cpu_n`) counts only while `cs1_n` is low. The *controller* strobe (`strb_ctl_n`) always counts.

Once an access has started, later cycles continue a four-beat burst. A two-bit counter steps when `adv_n` is low and holds when `adv_n` is high. The burst visits the word's low two address bits in interleaved order (start XOR count) or in linear order (start plus count, modulo 4). The `burst_lin` input, sampled at the start, picks the order. Read data leaves through an output register. The drive-enable `rdata_oe` stands in for a tristate pin and is gated asynchronously by `oe_n`. A sleep input parks the model without losing the array.

The controller holds three states:
- `ST_IDLE`: no burst is open.
- `ST_ACT`: a burst is open and later cycles continue it.
- `ST_SLEEP`: the model is parked.

Its transitions are:
- **start-selected**: IDLE/ACT to ACT, on a strobe while the chip is selected.
- **start-deselected**: IDLE/ACT to IDLE, on a strobe while the chip is deselected.
- **enter-sleep**: IDLE/ACT to SLEEP, while `sleep` is high.
- **wake**: SLEEP to IDLE, when `sleep` is low.

Any other cycle holds the current state.

Top module: `burst_sram`

## Requirements
- R1: After reset `rdata_oe` is low and no burst is open.
- R2: A strobe cycle with `cs1_n` high, `cs2` low or `cs3_n` high deselects the chip. That cycle writes nothing, and `rdata_oe` is low after the second following edge. Continuation cycles then do nothing until the next selected start.
- R3: A processor strobe while `cs1_n` is high is not a start. If a burst is open, that cycle acts as an ordinary continuation cycle.
- R4: A processor-started access always reads in its first cycle, and `gw_n`, `bwe_n`, `lane_en_n` and `adv_n` have no effect in that cycle. A write to that address needs the following cycle, with the write controls asserted.
- R5: A controller-started access whose write controls are asserted writes `wdata` at `addr` in that same cycle.
- R6: Write lanes are chosen as follows:
  - `gw_n` low writes all four lanes.
  - Otherwise `bwe_n` low writes each lane `i` whose `lane_en_n[i]` is low, where lane `i` is `wdata[8i+7:8i]`.
  - With no lane selected, the cycle is a read.
- R7: With `burst_lin`=0 at the start, the low two address bits of beat `n` are the start bits XOR `n`.
- R8: With `burst_lin`=1 at the start, the low two address bits of beat `n` are the start bits plus `n`, modulo 4. In both orders the upper address bits never change during a burst.
- R9: A continuation cycle with `adv_n` high accesses the same address as the previous beat. With `adv_n` low it accesses the next address in the burst order.
- R10: Read data for an access decided at edge k is on `rdata` with `rdata_oe` high after edge k+1. Each further beat follows one cycle later.
- R11: `oe_n` high forces `rdata_oe` low at once, without waiting for a clock edge.
- R12: Sleep behaves as follows:
  - While `sleep` is high, no access is made and any pending access is dropped.
  - `rdata_oe` is low during sleep and in the cycle after leaving it.
  - Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addr | input | AW | Word address, loaded on a start |
| wdata | input | 32 | Write data, four byte lanes |
| cs1_n | input | 1 | Chip enable, active low; also qualifies the processor strobe |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_en_n | input | 4 | Per-lane write enables, active low |
| burst_lin | input | 1 | Burst order: 0 interleaved, 1 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| rdata | output | 32 | Registered read data |
| rdata_oe | output | 1 | Drive enable for rdata |

## Verification
On every cycle, the assertions check three things:
- The data output goes quiet after a deselecting strobe, during sleep and after waking.
- A suspended beat leaves the burst address unchanged.
- The upper address bits stay fixed while a burst continues.

Only the bench's scenarios can show the following:
- Data values follow both burst orders from every start offset.
- Byte-lane merging is correct for all sixteen lane combinations.
- Writes from the processor strobe land one cycle late.
- Contents survive sleep.

The bench compares these against a shadow array that it updates itself.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACT   = 2'd1,
        ST_SLEEP = 2'd2
    } state_t;

    // Low two address bits of a burst beat in either order
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       lin);
        return lin ? (start + cnt) : (start ^ cnt);
    endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             strb_cpu_n,
    input  logic             strb_ctl_n,
    input  logic             cs1_n,
    input  logic             cs2,
    input  logic             cs3_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_en_n,
    output logic             ld_go,
    output logic             step_go,
    output logic             acc_rd,
    output logic             acc_wr,
    output logic [LANES-1:0] wr_mask
);
    import burst_sram_pkg::*;

    state_t state_q, state_d;

    logic             cpu_go, ctl_go, start, sel_ok, wr_req;
    logic [LANES-1:0] lane_sel;

    always_comb begin
        cpu_go   = !strb_cpu_n && !cs1_n;
        ctl_go   = !strb_ctl_n && !cpu_go;
        start    = cpu_go || ctl_go;
        sel_ok   = !cs1_n && cs2 && !cs3_n;
        lane_sel = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~lane_en_n : '0);
        wr_req   = |lane_sel;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ACT: begin
                if (sleep)      state_d = ST_SLEEP;
                else if (start) state_d = sel_ok ? ST_ACT : ST_IDLE;
            end
            ST_SLEEP: begin
                if (!sleep) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ld_go   = 1'b0;
        step_go = 1'b0;
        acc_rd  = 1'b0;
        acc_wr  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ACT: begin
                if (!sleep) begin
                    if (start) begin
                        if (sel_ok) begin
                            ld_go  = 1'b1;
                            acc_wr = ctl_go && wr_req;
                            acc_rd = !(ctl_go && wr_req);
                        end
                    end else if (state_q == ST_ACT) begin
                        step_go = !adv_n;
                        acc_wr  = wr_req;
                        acc_rd  = !wr_req;
                    end
                end
            end
            default: ;
        endcase
        wr_mask = acc_wr ? lane_sel : '0;
    end

endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_go,
    input  logic [AW-1:0] ld_addr,
    input  logic          ld_lin,
    input  logic          step_go,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr
);
    import burst_sram_pkg::*;

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic          lin_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            lin_q  <= 1'b0;
        end else if (ld_go) begin
            base_q <= ld_addr;
            cnt_q  <= '0;
            lin_q  <= ld_lin;
        end else if (step_go) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

    always_comb begin
        cur_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_q, lin_q)};
        nxt_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_q + 2'd1, lin_q)};
    end

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    rd_en,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*LANE_W-1:0] rd_word,
    output logic                    rd_valid
);
    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << AW;

    logic             wr_q, rd_q, vld_q;
    logic [LANES-1:0] mask_q;
    logic [AW-1:0]    waddr_q, raddr_q;
    logic [DW-1:0]    wdata_q;

    // Input register stage
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            vld_q   <= 1'b0;
            mask_q  <= '0;
            waddr_q <= '0;
            raddr_q <= '0;
            wdata_q <= '0;
        end else begin
            wr_q    <= wr_en;
            rd_q    <= rd_en;
            vld_q   <= rd_q;
            mask_q  <= wr_mask;
            waddr_q <= wr_addr;
            raddr_q <= rd_addr;
            wdata_q <= wr_data;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_l [DEPTH];
        logic [LANE_W-1:0] q_l;

        always_ff @(posedge clk) begin
            if (wr_q && mask_q[g] && !clear)
                mem_l[waddr_q] <= wdata_q[g*LANE_W +: LANE_W];
            if (rd_q && !clear)
                q_l <= mem_l[raddr_q];
        end

        assign rd_word[g*LANE_W +: LANE_W] = q_l;
    end

    assign rd_valid = vld_q;

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    strb_cpu_n,
    input  logic                    strb_ctl_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        lane_en_n,
    input  logic                    burst_lin,
    input  logic                    oe_n,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    localparam int DW = LANES * LANE_W;

    logic             ld_go, step_go, acc_rd, acc_wr, rd_valid;
    logic [LANES-1:0] wr_mask;
    logic [AW-1:0]    cur_addr, nxt_addr, acc_addr;
    logic [DW-1:0]    rd_word;

    burst_sram_ctrl #(.LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .cs1_n      (cs1_n),
        .cs2        (cs2),
        .cs3_n      (cs3_n),
        .adv_n      (adv_n),
        .gw_n       (gw_n),
        .bwe_n      (bwe_n),
        .lane_en_n  (lane_en_n),
        .ld_go      (ld_go),
        .step_go    (step_go),
        .acc_rd     (acc_rd),
        .acc_wr     (acc_wr),
        .wr_mask    (wr_mask)
    );

    burst_sram_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_go    (ld_go),
        .ld_addr  (addr),
        .ld_lin   (burst_lin),
        .step_go  (step_go),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr)
    );

    assign acc_addr = ld_go ? addr : (step_go ? nxt_addr : cur_addr);

    burst_sram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sleep),
        .wr_en    (acc_wr),
        .wr_mask  (wr_mask),
        .wr_addr  (acc_addr),
        .wr_data  (wdata),
        .rd_en    (acc_rd),
        .rd_addr  (acc_addr),
        .rd_word  (rd_word),
        .rd_valid (rd_valid)
    );

    assign rdata    = rd_word;
    assign rdata_oe = rd_valid && !oe_n;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep,
    input logic          strb_cpu_n,
    input logic          strb_ctl_n,
    input logic          cs1_n,
    input logic          cs2,
    input logic          cs3_n,
    input logic          rdata_oe,
    input logic          ld_go,
    input logic          step_go,
    input logic          acc_rd,
    input logic          acc_wr,
    input logic [AW-1:0] cur_addr
);
    logic strobe_any, desel;
    assign strobe_any = (!strb_cpu_n && !cs1_n) || !strb_ctl_n;
    assign desel      = cs1_n || !cs2 || cs3_n;

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_any && desel) |=> ##1 !rdata_oe);                         // R2

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !rdata_oe);                                             // R12

    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> !rdata_oe);                                      // R12

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_rd || acc_wr) && !ld_go && !step_go) |=> $stable(cur_addr)); // R9

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_rd || acc_wr) && !ld_go) |=> $stable(cur_addr[AW-1:2]));    // R8

endmodule

bind burst_sram burst_sram_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .cs1_n      (cs1_n),
    .cs2        (cs2),
    .cs3_n      (cs3_n),
    .rdata_oe   (rdata_oe),
    .ld_go      (ld_go),
    .step_go    (step_go),
    .acc_rd     (acc_rd),
    .acc_wr     (acc_wr),
    .cur_addr   (cur_addr)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam int DEPTH      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic          cs1_n, cs2, cs3_n, strb_cpu_n, strb_ctl_n, adv_n;
    logic          gw_n, bwe_n, burst_lin, oe_n, sleep;
    logic [3:0]    lane_en_n;
    logic [31:0]   rdata;
    logic          rdata_oe;

    logic [31:0] shadow [DEPTH];
    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_sram #(.AW(AW)) u_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .lane_en_n(lane_en_n),
        .burst_lin(burst_lin), .oe_n(oe_n), .sleep(sleep),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cs1_n = 0; cs2 = 1; cs3_n = 0;
        strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
        gw_n = 1; bwe_n = 1; lane_en_n = 4'hF;
    endtask

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_rd(input logic [AW-1:0] a, input string req);
        chk(rdata_oe === 1'b1 && rdata === shadow[a], req, rdata, shadow[a]);
    endtask

    // Controller-strobe write in one cycle; leaves idle inputs driven
    task automatic ctl_write(input logic [AW-1:0] a, input logic [31:0] d,
                             input logic g, input logic b, input logic [3:0] ln);
        idle_inputs();
        addr = a; wdata = d; strb_ctl_n = 0; gw_n = g; bwe_n = b; lane_en_n = ln;
        step();
        for (int i = 0; i < 4; i++)
            if (!g || (!b && !ln[i])) shadow[a][i*8 +: 8] = d[i*8 +: 8];
        idle_inputs();
    endtask

    task automatic rd1(input logic [AW-1:0] a, input string req);
        idle_inputs();
        addr = a; strb_ctl_n = 0;
        step();
        idle_inputs();
        step();
        chk_rd(a, req);
    endtask

    task automatic do_burst(input logic [AW-1:0] a, input logic lin,
                            input logic use_cpu, input logic [3:0] adv_pat,
                            input string req);
        logic [1:0]    cnt;
        logic [1:0]    lo;
        logic [AW-1:0] ea [4];
        cnt = 2'd0;
        for (int i = 0; i < 4; i++) begin
            if (i > 0 && adv_pat[i]) cnt = cnt + 2'd1;
            lo    = lin ? (a[1:0] + cnt) : (a[1:0] ^ cnt);
            ea[i] = {a[AW-1:2], lo};
            idle_inputs();
            if (i == 0) begin
                addr = a; burst_lin = lin;
                if (use_cpu) strb_cpu_n = 0; else strb_ctl_n = 0;
            end else begin
                adv_n = !adv_pat[i];
                burst_lin = !lin;   // order is fixed at the start
            end
            step();
            if (i > 0) chk_rd(ea[i-1], req);
        end
        idle_inputs();
        step();
        chk_rd(ea[3], req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0; addr = '0; wdata = '0; burst_lin = 0; oe_n = 0; sleep = 0;
        repeat (3) step();
        chk(rdata_oe === 1'b0, "R1 oe in reset", {31'd0, rdata_oe}, 32'd0);
        rst_n = 1;
        step();
        chk(rdata_oe === 1'b0, "R1 oe after reset", {31'd0, rdata_oe}, 32'd0);

        // R5: fill every word with controller writes
        for (int a = 0; a < DEPTH; a++)
            ctl_write(AW'(a), {8'(a), 8'(~a), 8'(a * 7), 8'h5A}, 1'b0, 1'b1, 4'hF);
        for (int a = 0; a < DEPTH; a += 5) rd1(AW'(a), "R5 fill readback");

        // R7 / R8 / R10: both orders, every start offset, both strobes
        for (int lin = 0; lin < 2; lin++)
            for (int b = 0; b < 4; b++)
                for (int off = 0; off < 4; off++)
                    do_burst(AW'(b * 20 % DEPTH) & ~AW'(3) | AW'(off), lin[0],
                             off[0], 4'b1110, lin ? "R8/R10 linear" : "R7/R10 interleaved");

        // R9: suspended beats
        do_burst(AW'(13), 1'b0, 1'b0, 4'b1010, "R9 suspend interleaved");
        do_burst(AW'(30), 1'b1, 1'b0, 4'b0100, "R9 suspend linear");

        // R6: every lane combination via byte-write enable
        for (int m = 0; m < 16; m++) begin
            ctl_write(AW'(40), {8'(m + 8'h40), 8'(m + 8'h30), 8'(m + 8'h20), 8'(m + 8'h10)},
                      1'b1, 1'b0, ~4'(m));
            rd1(AW'(40), "R6 lane merge");
        end
        // R6: global write overrides lane enables
        ctl_write(AW'(41), 32'hDEAD_BEEF, 1'b0, 1'b1, 4'hF);
        rd1(AW'(41), "R6 global write");
        // R6: lane enables without bwe_n write nothing
        ctl_write(AW'(41), 32'h1111_1111, 1'b1, 1'b1, 4'h0);
        rd1(AW'(41), "R6 no bwe");

        // R4: processor start ignores write controls; write lands next cycle
        idle_inputs();
        addr = AW'(50); wdata = 32'hAAAA_0001; strb_cpu_n = 0; gw_n = 0; adv_n = 0;
        step();
        idle_inputs();
        wdata = 32'hBBBB_0002; gw_n = 0;
        step();
        chk_rd(AW'(50), "R4 first cycle reads old data");
        shadow[50] = 32'hBBBB_0002;
        idle_inputs();
        step();
        rd1(AW'(50), "R4 second-cycle write");

        // R3: processor strobe with cs1_n high continues the open burst
        idle_inputs();
        addr = AW'(8); burst_lin = 0; strb_ctl_n = 0;
        step();
        idle_inputs();
        cs1_n = 1; strb_cpu_n = 0; addr = AW'(60); adv_n = 0;
        step();
        chk_rd(AW'(8), "R3 beat0");
        idle_inputs();
        step();
        chk_rd(AW'(9), "R3 continued beat");

        // R11: asynchronous output enable
        oe_n = 1; #1;
        chk(rdata_oe === 1'b0, "R11 oe_n high", {31'd0, rdata_oe}, 32'd0);
        oe_n = 0; #1;
        chk(rdata_oe === 1'b1, "R11 oe_n low", {31'd0, rdata_oe}, 32'd1);

        // R2: deselecting strobe with a write request
        idle_inputs();
        addr = AW'(20); wdata = 32'h0BAD_0BAD; strb_ctl_n = 0; cs2 = 0; gw_n = 0;
        step();
        idle_inputs();
        step();
        chk(rdata_oe === 1'b0, "R2 quiet after deselect", {31'd0, rdata_oe}, 32'd0);
        step();
        chk(rdata_oe === 1'b0, "R2 no continuation", {31'd0, rdata_oe}, 32'd0);
        rd1(AW'(20), "R2 no write when deselected");
        idle_inputs();
        addr = AW'(21); strb_ctl_n = 0; cs3_n = 1;
        step();
        idle_inputs();
        step();
        chk(rdata_oe === 1'b0, "R2 cs3_n deselect", {31'd0, rdata_oe}, 32'd0);

        // R12: sleep while deselected, contents retained
        for (int i = 0; i < 3; i++) begin
            sleep = 1;
            step();
            chk(rdata_oe === 1'b0, "R12 asleep", {31'd0, rdata_oe}, 32'd0);
        end
        sleep = 0;
        step();
        chk(rdata_oe === 1'b0, "R12 after wake", {31'd0, rdata_oe}, 32'd0);
        for (int a = 0; a < DEPTH; a += 9) rd1(AW'(a), "R12 retained");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule